// File: doc/BRIEF.md
# Multi-Mode Barrel Shift Unit

A purely combinational shifter that turns a data operand, a shift-amount operand and a three-bit mode code into a result of configurable width. The data operand is first widened to the larger of its own width and the result width. It is sign-extended when the data is declared signed and zero-extended otherwise. The widened value is then shifted left or right in a logarithmic barrel. Only the low result-width bits are presented.

Besides the four plain shifts, two modes read the amount differently. In the bidirectional mode the sign of the amount picks the direction. The window mode takes the result-width slice of the raw data that begins at a signed or unsigned bit offset. Alongside the result, a per-bit valid mask marks which result bits hold real data. The widths of data, amount and result, and whether data and amount are signed, are parameters of the unit.

Top module: `barrel_shift_unit`

## Requirements
- R1: Mode code 0 shifts the extended data left by the amount read as unsigned, fills the vacated low bits with zero, and outputs the low RES_W bits.
- R2: Mode code 2 produces exactly the result of mode code 0 for every data and amount value.
- R3: Mode code 1 shifts the extended data right and fills the vacated top bits with zero. It reads the amount as unsigned even when AMT_SIGNED is 1.
- R4: Mode code 3 shifts right and fills the vacated top bits with copies of the data sign bit when DATA_SIGNED is 1. When DATA_SIGNED is 0 it fills them with zero.
- R5: A shift distance of at least EXT_W = max(DATA_W, RES_W) gives all zeros for left and logical right shifts. It gives all copies of the sign for mode code 3 with signed data.
- R6: Mode code 4 with AMT_SIGNED=0, or with a non-negative amount, behaves as a logical right shift by the amount.
- R7: Mode code 4 with AMT_SIGNED=1 and a negative two's-complement amount shifts left by the magnitude. This includes the most negative amount, -2^(AMT_W-1).
- R8: Mode code 5 sets result bit i to data bit (offset + i) and valid bit i to 1. The offset is the amount, read as two's complement when AMT_SIGNED is 1 and unsigned otherwise.
- R9: In mode code 5, result bits whose position offset + i falls below 0 or at or above DATA_W read 0, and their valid bits read 0.
- R10: For mode codes 0 to 4 every valid-mask bit is 1. Mode codes 6 and 7 drive the result and the valid mask to all zeros.
- R11: At amount 0 in mode code 0 the result equals the data sign-extended (DATA_SIGNED=1) or zero-extended (DATA_SIGNED=0) to EXT_W, truncated to RES_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | DATA_W | Data operand |
| amountIn | input | AMT_W | Shift amount or window offset |
| modeSel | input | 3 | Operation code (0 to 7) |
| result | output | RES_W | Shifted value or extracted window |
| validMask | output | RES_W | Per-bit flag: result bit came from real data |

## Verification
Several behaviours can meet in a single evaluation. A negative amount in bidirectional mode, whose magnitude reaches past the extended width, applies the direction flip and the over-range clamp together. A window offset that straddles an edge of the data returns real bits and filled bits in the same result. The bench drives both situations on purpose: the most negative amount, offsets of -2 and near the top of the data, and a narrow unsigned second instance where every amount range is reachable. It also drives many random vectors. Each result and mask is judged bit by bit against an integer model in the bench.

// File: rtl/shu_pkg.sv
package shu_pkg;

  localparam logic [2:0] MODE_LSL   = 3'd0;
  localparam logic [2:0] MODE_LSR   = 3'd1;
  localparam logic [2:0] MODE_ASL   = 3'd2;
  localparam logic [2:0] MODE_ASR   = 3'd3;
  localparam logic [2:0] MODE_BIDIR = 3'd4;
  localparam logic [2:0] MODE_WIN   = 3'd5;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic goLeft;
    logic fillSign;
    logic useWindow;
    logic killAll;
  } shiftCtl_t;

endpackage

// File: rtl/shu_ctrl.sv
module shu_ctrl
  import shu_pkg::*;
#(
  parameter int AMT_W      = 5,
  parameter bit AMT_SIGNED = 1'b1,
  parameter int EXT_W      = 12,
  localparam int MAG_W     = AMT_W + 1
) (
  input  logic [2:0]        modeSel,
  input  logic [AMT_W-1:0]  amount,
  input  logic              dataNeg,
  output shiftCtl_t         ctl,
  output logic [MAG_W-1:0]  magnitude,
  output logic              overRange,
  output logic signed [31:0] winBase
);

  logic amtNeg;
  assign amtNeg = AMT_SIGNED && amount[AMT_W-1];

  always_comb begin
    ctl       = '0;
    magnitude = {1'b0, amount};
    case (modeSel)
      MODE_LSL, MODE_ASL: ctl.goLeft = 1'b1;
      MODE_LSR:           ctl.goLeft = 1'b0;
      MODE_ASR:           ctl.fillSign = dataNeg;
      MODE_BIDIR: begin
        if (amtNeg) begin
          ctl.goLeft = 1'b1;
          magnitude  = MAG_W'(0) - {amount[AMT_W-1], amount};
        end
      end
      MODE_WIN:           ctl.useWindow = 1'b1;
      default:            ctl.killAll = 1'b1;
    endcase
  end

  assign overRange = ({{(32-MAG_W){1'b0}}, magnitude} >= 32'(EXT_W));

  generate
    if (AMT_SIGNED) begin : g_sbase
      assign winBase = 32'($signed(amount));
    end else begin : g_ubase
      assign winBase = $signed(32'(amount));
    end
  endgenerate

endmodule

// File: rtl/shu_dpath.sv
module shu_dpath
  import shu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RES_W  = 12,
  parameter int EXT_W  = 12,
  parameter int MAG_W  = 6,
  localparam int STG   = $clog2(EXT_W)
) (
  input  logic [EXT_W-1:0]   extData,
  input  logic [DATA_W-1:0]  rawData,
  input  shiftCtl_t          ctl,
  input  logic [MAG_W-1:0]   magnitude,
  input  logic               overRange,
  input  logic signed [31:0] winBase,
  output logic [RES_W-1:0]   result,
  output logic [RES_W-1:0]   validMask
);

  logic [EXT_W-1:0] stageL [0:STG];
  logic [EXT_W-1:0] stageR [0:STG];
  logic [EXT_W-1:0] shifted;
  logic [RES_W-1:0] winBits;
  logic [RES_W-1:0] winOk;

  assign stageL[0] = extData;
  assign stageR[0] = extData;

  genvar s;
  generate
    for (s = 0; s < STG; s++) begin : g_stage
      localparam int SH = 1 << s;
      if (s < MAG_W) begin : g_live
        assign stageL[s+1] = magnitude[s] ? {stageL[s][EXT_W-SH-1:0], {SH{1'b0}}} : stageL[s];
        assign stageR[s+1] = magnitude[s] ? {{SH{ctl.fillSign}}, stageR[s][EXT_W-1:SH]} : stageR[s];
      end else begin : g_pass
        assign stageL[s+1] = stageL[s];
        assign stageR[s+1] = stageR[s];
      end
    end
  endgenerate

  always_comb begin
    if (overRange)
      shifted = ctl.goLeft ? '0 : {EXT_W{ctl.fillSign}};
    else
      shifted = ctl.goLeft ? stageL[STG] : stageR[STG];
  end

  always_comb begin
    winBits = '0;
    winOk   = '0;
    for (int i = 0; i < RES_W; i++) begin
      for (int j = 0; j < DATA_W; j++) begin
        if (winBase + 32'(i) == 32'(j)) begin
          winBits[i] = rawData[j];
          winOk[i]   = 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (ctl.killAll) begin
      result    = '0;
      validMask = '0;
    end else if (ctl.useWindow) begin
      result    = winBits;
      validMask = winOk;
    end else begin
      result    = shifted[RES_W-1:0];
      validMask = '1;
    end
  end

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import shu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int AMT_W       = 5,
  parameter int RES_W       = 12,
  parameter bit DATA_SIGNED = 1'b1,
  parameter bit AMT_SIGNED  = 1'b1,
  localparam int EXT_W      = (DATA_W > RES_W) ? DATA_W : RES_W,
  localparam int MAG_W      = AMT_W + 1
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [AMT_W-1:0]  amountIn,
  input  logic [2:0]        modeSel,
  output logic [RES_W-1:0]  result,
  output logic [RES_W-1:0]  validMask
);

  shiftCtl_t          ctl;
  logic [MAG_W-1:0]   magnitude;
  logic               overRange;
  logic signed [31:0] winBase;
  logic [EXT_W-1:0]   extData;
  logic               dataNeg;

  assign dataNeg = DATA_SIGNED && dataIn[DATA_W-1];

  generate
    if (EXT_W == DATA_W) begin : g_noext
      assign extData = dataIn;
    end else begin : g_ext
      assign extData = {{(EXT_W-DATA_W){dataNeg}}, dataIn};
    end
  endgenerate

  shu_ctrl #(
    .AMT_W(AMT_W), .AMT_SIGNED(AMT_SIGNED), .EXT_W(EXT_W)
  ) u_ctrl (
    .modeSel(modeSel), .amount(amountIn), .dataNeg(dataNeg),
    .ctl(ctl), .magnitude(magnitude), .overRange(overRange), .winBase(winBase)
  );

  shu_dpath #(
    .DATA_W(DATA_W), .RES_W(RES_W), .EXT_W(EXT_W), .MAG_W(MAG_W)
  ) u_dpath (
    .extData(extData), .rawData(dataIn), .ctl(ctl), .magnitude(magnitude),
    .overRange(overRange), .winBase(winBase),
    .result(result), .validMask(validMask)
  );

  always_comb begin
    // R10
    if (!ctl.useWindow && !ctl.killAll)
      shift_mask_chk: assert (validMask == {RES_W{1'b1}}) else $error("shift mask not full");
  end

  always_comb begin
    // R9
    if (ctl.useWindow)
      win_fill_chk: assert ((result & ~validMask) == '0) else $error("window fill not zero");
  end

  always_comb begin
    // R10
    if (ctl.killAll)
      reserved_quiet_chk: assert (result == '0 && validMask == '0) else $error("reserved code active");
  end

  always_comb begin
    // R5
    if (overRange && !ctl.useWindow && !ctl.killAll)
      over_range_chk: assert (result == {RES_W{ctl.fillSign}}) else $error("over-range clamp wrong");
  end

  always_comb begin
    // R4
    if (ctl.fillSign)
      sar_fill_chk: assert (modeSel == MODE_ASR && DATA_SIGNED && dataIn[DATA_W-1]) else $error("sign fill misuse");
  end

endmodule

// File: tb/barrel_shift_unit_bench.sv
`timescale 1ns/1ps
module barrel_shift_unit_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // instance A: signed data and amount, result wider than data
  logic [7:0]  dA;
  logic [4:0]  aA;
  logic [2:0]  mA;
  logic [11:0] rA, vA;
  // instance B: unsigned, result narrower than data
  logic [5:0]  dB;
  logic [2:0]  aB;
  logic [2:0]  mB;
  logic [3:0]  rB, vB;

  barrel_shift_unit u_barrel_shift_unit (
    .dataIn(dA), .amountIn(aA), .modeSel(mA), .result(rA), .validMask(vA)
  );

  barrel_shift_unit #(
    .DATA_W(6), .AMT_W(3), .RES_W(4), .DATA_SIGNED(1'b0), .AMT_SIGNED(1'b0)
  ) u_alt (
    .dataIn(dB), .amountIn(aB), .modeSel(mB), .result(rB), .validMask(vB)
  );

  function automatic longint msk(int w);
    return (longint'(1) << w) - 1;
  endfunction

  function automatic void refm(input int dw, input int aw, input int rw, input bit ds,
                               input bit as, input int mode, input longint data,
                               input longint amt, output longint r, output longint v);
    int ew;
    longint d, dv, ue, a, sa, p;
    ew = (dw > rw) ? dw : rw;
    d  = data & msk(dw);
    dv = (ds && d[dw-1]) ? d - (longint'(1) << dw) : d;
    ue = dv & msk(ew);
    a  = amt & msk(aw);
    sa = (as && a[aw-1]) ? a - (longint'(1) << aw) : a;
    r = 0;
    v = msk(rw);
    case (mode)
      0, 2: r = (a >= ew) ? 0 : (ue << a);
      1:    r = (a >= ew) ? 0 : (ue >> a);
      3: begin
        if (ds) r = (a >= ew) ? ((dv < 0) ? -1 : 0) : (dv >>> a);
        else    r = (a >= ew) ? 0 : (ue >> a);
      end
      4: begin
        if (sa < 0) r = (-sa >= ew) ? 0 : (ue << (-sa));
        else        r = (a >= ew) ? 0 : (ue >> a);
      end
      5: begin
        v = 0;
        for (int i = 0; i < rw; i++) begin
          p = sa + i;
          if (p >= 0 && p < dw) begin
            v = v | (longint'(1) << i);
            if (d[p]) r = r | (longint'(1) << i);
          end
        end
      end
      default: v = 0;
    endcase
    r = r & msk(rw);
    v = v & msk(rw);
  endfunction

  function automatic string tagFor(int mode, longint amt, int aw, bit as, int ew,
                                   int rw, bit isMask, longint expV);
    longint a;
    a = amt & msk(aw);
    if (isMask) begin
      if (mode == 5) return (expV == msk(rw)) ? "R8" : "R9";
      return "R10";
    end
    case (mode)
      0: return (a >= ew) ? "R5" : ((a == 0) ? "R11" : "R1");
      2: return "R2";
      1: return (a >= ew) ? "R5" : "R3";
      3: return (a >= ew) ? "R5" : "R4";
      4: return (as && a[aw-1]) ? "R7" : "R6";
      5: return (expV == msk(rw)) ? "R8" : "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, string what, longint got, longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic vec(int ma, longint da, longint aa, int mb, longint db, longint ab);
    longint er, ev;
    @(negedge clk);
    mA = 3'(ma); dA = 8'(da); aA = 5'(aa);
    mB = 3'(mb); dB = 6'(db); aB = 3'(ab);
    @(posedge clk);
    #1;
    refm(8, 5, 12, 1'b1, 1'b1, ma, da, aa, er, ev);
    check(tagFor(ma, aa, 5, 1'b1, 12, 12, 1'b0, ev), "A result", longint'(rA), er);
    check(tagFor(ma, aa, 5, 1'b1, 12, 12, 1'b1, ev), "A mask", longint'(vA), ev);
    refm(6, 3, 4, 1'b0, 1'b0, mb, db, ab, er, ev);
    check(tagFor(mb, ab, 3, 1'b0, 6, 4, 1'b0, ev), "B result", longint'(rB), er);
    check(tagFor(mb, ab, 3, 1'b0, 6, 4, 1'b1, ev), "B mask", longint'(vB), ev);
  endtask

  initial begin
    mA = 0; dA = 0; aA = 0; mB = 0; dB = 0; aB = 0;
    // R11 extension at zero shift
    vec(0, 'h81, 0, 0, 'h21, 0);
    // R1 / R2 left shifts agree
    vec(0, 'h81, 3, 0, 'h2D, 2);
    vec(2, 'h81, 3, 2, 'h2D, 2);
    // R3 amount read unsigned even with signed amount (16, not -16)
    vec(1, 'h81, 'h10, 1, 'h3F, 5);
    vec(1, 'hF0, 4, 1, 'h3F, 1);
    // R4 sign fill vs unsigned zero fill
    vec(3, 'h81, 2, 3, 'h3F, 2);
    // R5 over-range clamp
    vec(3, 'h81, 'h0F, 0, 'h3F, 6);
    vec(0, 'h7F, 'h0C, 3, 'h3F, 7);
    // R6 / R7 bidirectional, including most negative amount
    vec(4, 'h81, 3, 4, 'h3F, 3);
    vec(4, 'h81, 'h1F, 4, 'h3F, 7);
    vec(4, 'hFF, 'h10, 4, 'h01, 0);
    vec(4, 'h55, 'h15, 4, 'h2A, 1);
    // R8 / R9 windows: inside, straddling below and above
    vec(5, 'h81, 'h1E, 5, 'h2D, 3);
    vec(5, 'hA5, 2, 5, 'h2D, 1);
    vec(5, 'hA5, 'h0F, 5, 'h2D, 6);
    vec(5, 'hA5, 'h10, 5, 'h2D, 0);
    // R10 reserved codes
    vec(6, 'hFF, 3, 7, 'h3F, 3);
    vec(7, 'h12, 1, 6, 'h15, 1);
    for (int k = 0; k < 3000; k++) begin
      vec(int'($urandom_range(7)), longint'($urandom), longint'($urandom),
          int'($urandom_range(7)), longint'($urandom), longint'($urandom));
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule